// File: doc/BRIEF.md
# Multichannel Conversion Result FIFO with Fill Trigger

This block is the digital back end of a converter that samples one or two channels at the same instant. The host runs it from a single system clock. A free-running conversion clock comes in as a level, and the block detects its rising edges. On each rising edge in continuous mode, the sample pair taken on that edge enters a fixed-length result pipeline. The pair that leaves the pipeline is pushed into a 16-word result FIFO. When two channels are active, channel A goes in first and channel B second.

A host read port pops one word per strobe, with the oldest word always shown on the read data bus. A data-available flag tells the host that the FIFO fill has reached a programmable trigger level. A small configuration word sets the following:
- continuous or single-conversion mode;
- one or two channels;
- the trigger level.

In single-conversion mode the conversion clock is ignored. Instead, a start strobe pushes the words present on the input bus at that moment.

Top module: `convfifo_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, the block shows `empty`=1, `full`=0, `fill`=0, `data_av`=0 and `overflow`=0. Reset also empties the result pipeline and selects continuous mode, one channel and trigger level 1.
- R2: In continuous mode (config bit 1 = 0), each rising edge of `conv_clk` pushes the sample captured five edges earlier. The first five edges after reset, or after a configuration write, push nothing. `fill` shows the push in the system-clock cycle in which `conv_clk` is first seen high.
- R3: In continuous mode, `int_start` has no effect on the FIFO.
- R4: With config bit 0 = 1 (two channels), each conversion pushes two words, the `ch_a` word first and then the `ch_b` word. With bit 0 = 0, it pushes only the `ch_a` word.
- R5: In single-conversion mode (config bit 1 = 1), `conv_clk` edges are ignored. Each `int_start` pulse pushes the current `ch_a` word, and with two channels also the current `ch_b` word, in that order.
- R6: Config bits 5:2 request a trigger level. The values 1, 2, 4 and 8 are accepted, except that 1 is refused when two channels are active. Any refused value selects the channel count as the level. `data_av` is high in the cycle after a cycle in which `fill` is at or above the level, and low in the cycle after `fill` drops below it.
- R7: A push of n words is accepted only if the fill before this cycle's pop, plus n, is at most 16. Otherwise all n words are dropped and `overflow` is set. `overflow` stays set until the next configuration write.
- R8: `rd_data` always shows the oldest stored word. `rd_en` removes it when the FIFO is not empty. `rd_en` on an empty FIFO changes nothing.
- R9: A configuration write (`cfg_we`) clears the result pipeline and `overflow`, keeps the stored words, and pushes nothing in that cycle.
- R10: `full` is 1 exactly when `fill` is 16, and `empty` is 1 exactly when `fill` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_clk | input | 1 | Free-running conversion clock, synchronous to clk |
| int_start | input | 1 | Conversion start strobe for single-conversion mode |
| ch_a | input | 12 | Channel A result word |
| ch_b | input | 12 | Channel B result word |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Config: bit0 two channels, bit1 single mode, bits 5:2 trigger level |
| rd_en | input | 1 | Pop strobe |
| rd_data | output | 12 | Oldest stored word |
| fill | output | 5 | Number of stored words |
| empty | output | 1 | FIFO holds no word |
| full | output | 1 | FIFO holds 16 words |
| data_av | output | 1 | Fill has reached the trigger level |
| overflow | output | 1 | Sticky dropped-push flag |

## Verification
The assertions take for granted that `conv_clk` is already synchronous to `clk` and stays at each level for at least one system cycle. They also assume that a configuration write never falls in the same cycle as a conversion edge or a start pulse. The stimulus toggles `conv_clk` only at falling edges of `clk`, with random run lengths of one or more cycles. Configuration writes are issued on their own and otherwise at random intervals. Reads, start pulses and sample words are drawn at random from a fixed seed.

// File: rtl/convfifo_pkg.sv
package convfifo_pkg;

    // Maps a requested trigger level to the level actually used.
    function automatic int pick_level(logic [3:0] req, logic dual);
        int r;
        r = int'(req);
        if ((r == 1 && !dual) || r == 2 || r == 4 || r == 8)
            return r;
        return dual ? 2 : 1;
    endfunction

endpackage

// File: rtl/convfifo_edge.sv
module convfifo_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise
);
    logic sig_d, sig_q;

    always_comb begin
        sig_d = sig;
    end

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig_d;
    end

    assign rise = sig & ~sig_q;

endmodule

// File: rtl/convfifo_pipe.sv
module convfifo_pipe #(
    parameter int unsigned WORD_W = 12,
    parameter int unsigned STAGES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              shift,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_a,
    output logic [WORD_W-1:0] out_b
);
    typedef struct packed {
        logic              v;
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
    } stage_t;

    stage_t [STAGES-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else if (shift) begin
            for (int i = STAGES - 1; i > 0; i--) begin
                st_d[i] = st_q[i-1];
            end
            st_d[0] = '{v: 1'b1, a: in_a, b: in_b};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q[STAGES-1].v;
    assign out_a     = st_q[STAGES-1].a;
    assign out_b     = st_q[STAGES-1].b;

    // R9: a flush leaves no valid word at the pipeline output
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> !out_valid);

endmodule

// File: rtl/convfifo_buf.sv
module convfifo_buf #(
    parameter int unsigned WORD_W = 12,
    parameter int unsigned DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [1:0]                 push_n,
    input  logic [WORD_W-1:0]          push_a,
    input  logic [WORD_W-1:0]          push_b,
    input  logic                       pop,
    input  logic                       clr_ovf,
    output logic [WORD_W-1:0]          head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full,
    output logic                       ovf
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef logic [WORD_W-1:0] word_t;
    typedef struct packed {
        word_t [DEPTH-1:0] mem;
        logic  [AW-1:0]    wptr;
        logic  [AW-1:0]    rptr;
        logic  [CW-1:0]    count;
        logic              ovf;
    } buf_t;

    buf_t s_d, s_q;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic          do_pop;
    logic          fits;
    logic [1:0]    taken;
    logic [AW-1:0] wnext;

    always_comb begin
        s_d    = s_q;
        do_pop = pop && (s_q.count != '0);
        fits   = (int'(s_q.count) + int'(push_n)) <= int'(DEPTH);
        taken  = 2'd0;
        wnext  = bump(s_q.wptr);
        if (do_pop) s_d.rptr = bump(s_q.rptr);
        if (push_n != 2'd0) begin
            if (fits) begin
                taken = push_n;
                s_d.mem[s_q.wptr] = push_a;
                if (push_n == 2'd2) begin
                    s_d.mem[wnext] = push_b;
                    s_d.wptr = bump(wnext);
                end else begin
                    s_d.wptr = wnext;
                end
            end else begin
                s_d.ovf = 1'b1;
            end
        end
        if (clr_ovf) s_d.ovf = 1'b0;
        s_d.count = s_q.count - CW'(do_pop) + CW'(taken);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign head  = s_q.mem[s_q.rptr];
    assign count = s_q.count;
    assign empty = (s_q.count == '0);
    assign full  = (s_q.count == CW'(DEPTH));
    assign ovf   = s_q.ovf;

    // R7: fill never goes past the depth
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= int'(DEPTH));
    // R7: the drop flag holds until cleared
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr_ovf) |=> ovf);
    // R8: popping an empty FIFO with no push leaves it empty
    a_r8_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && push_n == 2'd0) |=> empty);

endmodule

// File: rtl/convfifo_top.sv
module convfifo_top #(
    parameter int unsigned WORD_W  = 12,
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned LATENCY = 5,
    parameter int unsigned CFG_W   = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       conv_clk,
    input  logic                       int_start,
    input  logic [WORD_W-1:0]          ch_a,
    input  logic [WORD_W-1:0]          ch_b,
    input  logic                       cfg_we,
    input  logic [CFG_W-1:0]           cfg_wdata,
    input  logic                       rd_en,
    output logic [WORD_W-1:0]          rd_data,
    output logic [$clog2(DEPTH+1)-1:0] fill,
    output logic                       empty,
    output logic                       full,
    output logic                       data_av,
    output logic                       overflow
);
    import convfifo_pkg::*;

    localparam int unsigned LVL_W      = $clog2(DEPTH + 1);
    localparam int unsigned BIT_DUAL   = 0;
    localparam int unsigned BIT_SINGLE = 1;
    localparam int unsigned LVL_LSB    = 2;

    typedef struct packed {
        logic             dual;
        logic             single;
        logic [LVL_W-1:0] level;
        logic             av;
    } ctl_t;

    ctl_t s_d, s_q;

    logic              rise;
    logic              cont;
    logic              shift;
    logic              pipe_v;
    logic [WORD_W-1:0] pipe_a, pipe_b;
    logic [1:0]        push_n;
    logic [WORD_W-1:0] push_a, push_b;
    logic [LVL_W-1:0]  fill_w;

    convfifo_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  (conv_clk),
        .rise (rise)
    );

    convfifo_pipe #(.WORD_W(WORD_W), .STAGES(LATENCY)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .flush     (cfg_we),
        .shift     (shift),
        .in_a      (ch_a),
        .in_b      (ch_b),
        .out_valid (pipe_v),
        .out_a     (pipe_a),
        .out_b     (pipe_b)
    );

    convfifo_buf #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .push_n  (push_n),
        .push_a  (push_a),
        .push_b  (push_b),
        .pop     (rd_en),
        .clr_ovf (cfg_we),
        .head    (rd_data),
        .count   (fill_w),
        .empty   (empty),
        .full    (full),
        .ovf     (overflow)
    );

    always_comb begin
        s_d    = s_q;
        cont   = !s_q.single;
        shift  = cont && rise && !cfg_we;
        push_n = 2'd0;
        push_a = pipe_a;
        push_b = pipe_b;
        if (!cfg_we) begin
            if (shift && pipe_v) begin
                push_n = s_q.dual ? 2'd2 : 2'd1;
            end else if (!cont && int_start) begin
                push_n = s_q.dual ? 2'd2 : 2'd1;
                push_a = ch_a;
                push_b = ch_b;
            end
        end
        s_d.av = (fill_w >= s_q.level);
        if (cfg_we) begin
            s_d.dual   = cfg_wdata[BIT_DUAL];
            s_d.single = cfg_wdata[BIT_SINGLE];
            s_d.level  = LVL_W'(pick_level(cfg_wdata[LVL_LSB +: 4], cfg_wdata[BIT_DUAL]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{dual: 1'b0, single: 1'b0, level: LVL_W'(1), av: 1'b0};
        else     s_q <= s_d;
    end

    assign fill    = fill_w;
    assign data_av = s_q.av;

    // R3: a start strobe alone leaves the fill untouched in continuous mode
    a_r3_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (!s_q.single && int_start && !rise && !rd_en && !cfg_we) |=> $stable(fill));
    // R6: two empty cycles in a row mean no data-available
    a_r6_quiet_when_empty: assert property (@(posedge clk) disable iff (rst)
        (empty && $past(empty)) |-> !data_av);
    // R5: conversion edges push nothing in single-conversion mode
    a_r5_edge_ignored: assert property (@(posedge clk) disable iff (rst)
        (s_q.single && !int_start && !rd_en) |=> $stable(fill));

endmodule

// File: tb/sim_convfifo_top.sv
module sim_convfifo_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_clk = 1'b0, int_start = 1'b0, cfg_we = 1'b0, rd_en = 1'b0;
    logic [11:0] ch_a = '0, ch_b = '0;
    logic [5:0]  cfg_wdata = '0;
    logic [11:0] rd_data;
    logic [4:0]  fill;
    logic        empty, full, data_av, overflow;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model state
    int mq[$];
    int pv[5], pa[5], pb[5];
    bit mprev, mdual, msingle, movf, mav;
    int mlvl;

    always #4 clk = ~clk;

    convfifo_top u0 (
        .clk(clk), .rst(rst), .conv_clk(conv_clk), .int_start(int_start),
        .ch_a(ch_a), .ch_b(ch_b), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rd_en(rd_en), .rd_data(rd_data), .fill(fill), .empty(empty),
        .full(full), .data_av(data_av), .overflow(overflow)
    );

    function automatic int exp_level(int req, bit dual);
        if ((req == 1 && !dual) || req == 2 || req == 4 || req == 8) return req;
        return dual ? 2 : 1;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        mq.delete();
        for (int i = 0; i < 5; i++) begin pv[i] = 0; pa[i] = 0; pb[i] = 0; end
        mprev = 0; mdual = 0; msingle = 0; movf = 0; mav = 0; mlvl = 1;
    endtask

    task automatic check_all();
        chk(fill == 5'(mq.size()), "R2", "fill", fill, mq.size());
        chk(empty == (mq.size() == 0), "R10", "empty", empty, mq.size() == 0);
        chk(full == (mq.size() == 16), "R10", "full", full, mq.size() == 16);
        chk(data_av == mav, "R6", "data_av", data_av, mav);
        chk(overflow == movf, "R7", "overflow", overflow, movf);
        if (mq.size() > 0) chk(rd_data == 12'(mq[0]), "R8", "rd_data", rd_data, mq[0]);
    endtask

    // drive one cycle, advance the model, check after the falling edge
    task automatic cyc(bit c, bit st, bit rd, bit we, int wd, int a, int b);
        bit rise, avn, pop, fits;
        int n, wa, wb;
        conv_clk = c; int_start = st; rd_en = rd; cfg_we = we;
        cfg_wdata = 6'(wd); ch_a = 12'(a); ch_b = 12'(b);
        rise = c && !mprev; mprev = c;
        n = 0; wa = 0; wb = 0;
        if (!we) begin
            if (!msingle && rise) begin
                if (pv[4] != 0) begin n = mdual ? 2 : 1; wa = pa[4]; wb = pb[4]; end
                for (int i = 4; i > 0; i--) begin pv[i] = pv[i-1]; pa[i] = pa[i-1]; pb[i] = pb[i-1]; end
                pv[0] = 1; pa[0] = a & 12'hfff; pb[0] = b & 12'hfff;
            end else if (msingle && st) begin
                n = mdual ? 2 : 1; wa = a & 12'hfff; wb = b & 12'hfff;
            end
        end else begin
            for (int i = 0; i < 5; i++) pv[i] = 0;
        end
        avn = mq.size() >= mlvl;
        pop = rd && mq.size() > 0;
        fits = (mq.size() + n) <= 16;
        if (pop) void'(mq.pop_front());
        if (n > 0) begin
            if (fits) begin mq.push_back(wa); if (n == 2) mq.push_back(wb); end
            else movf = 1;
        end
        if (we) begin
            movf = 0; mdual = wd[0]; msingle = wd[1]; mlvl = exp_level((wd >> 2) & 15, wd[0]);
        end
        mav = avn;
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic cfg(int wd);
        cyc(0, 0, 0, 1, wd, 0, 0);
    endtask

    task automatic edge_pair(int a, int b);
        cyc(1, 0, 0, 0, 0, a, b);
        cyc(0, 0, 0, 0, 0, a, b);
    endtask

    task automatic drain();
        while (mq.size() > 0) cyc(0, 0, 1, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(empty && !full && fill == 0 && !data_av && !overflow, "R1", "reset", fill, 0);
        check_all();

        // R2: continuous single channel, level 4, five-edge latency
        cfg(4 << 2);
        for (int k = 1; k <= 5; k++) edge_pair(100 + k, 200 + k);
        chk(fill == 0, "R2", "fill after five edges", fill, 0);
        edge_pair(106, 206);
        chk(fill == 1 && rd_data == 101, "R2", "first word", rd_data, 101);
        // R3: start strobe ignored in continuous mode
        cyc(0, 1, 0, 0, 0, 55, 66);
        cyc(0, 1, 0, 0, 0, 55, 66);
        chk(fill == 1, "R3", "fill after start", fill, 1);
        for (int k = 7; k <= 9; k++) edge_pair(100 + k, 200 + k);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk(data_av == 1, "R6", "data_av at level 4", data_av, 1);
        // R8: read back in order
        for (int k = 1; k <= 4; k++) begin
            chk(rd_data == 12'(100 + k), "R8", "read order", rd_data, 100 + k);
            cyc(0, 0, 1, 0, 0, 0, 0);
        end
        cyc(0, 0, 1, 0, 0, 0, 0);
        chk(empty && fill == 0, "R8", "pop on empty", fill, 0);

        // R4: two channels, level 2
        cfg(1 | (2 << 2));
        for (int k = 1; k <= 6; k++) edge_pair(300 + k, 400 + k);
        chk(fill == 2, "R4", "two words per edge", fill, 2);
        chk(rd_data == 301, "R4", "channel A first", rd_data, 301);
        cyc(0, 0, 1, 0, 0, 0, 0);
        chk(rd_data == 401, "R4", "channel B second", rd_data, 401);
        drain();

        // R5 and R6: single mode, refused level 3 falls back to 1
        cfg(2 | (3 << 2));
        edge_pair(1, 2);
        chk(fill == 0, "R5", "edge ignored", fill, 0);
        cyc(0, 1, 0, 0, 0, 77, 88);
        chk(fill == 1 && rd_data == 77 && data_av == 0, "R5", "start push", rd_data, 77);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk(data_av == 1, "R6", "fallback level 1", data_av, 1);
        cyc(0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk(data_av == 0, "R6", "deassert below level", data_av, 0);

        // R6: two channels refuse level 1
        cfg(3 | (1 << 2));
        cyc(0, 1, 0, 0, 0, 5, 6);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk(data_av == 1, "R6", "dual fallback level 2", data_av, 1);
        drain();

        // R7, R10: fill to full, then overflow
        cfg(2 | (8 << 2));
        for (int k = 0; k < 16; k++) cyc(0, 1, 0, 0, 0, 500 + k, 0);
        chk(full == 1 && fill == 16, "R10", "full", fill, 16);
        cyc(0, 1, 0, 0, 0, 999, 0);
        chk(overflow == 1 && fill == 16, "R7", "drop and flag", overflow, 1);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk(overflow == 1, "R7", "sticky", overflow, 1);
        // R9: config write clears flag, keeps words
        cfg(2 | (8 << 2));
        chk(overflow == 0 && fill == 16, "R9", "clear keeps words", fill, 16);
        drain();

        // R9: config write flushes the pipeline in continuous mode
        cfg(4 << 2);
        for (int k = 0; k < 4; k++) edge_pair(k, k);
        cfg(4 << 2);
        for (int k = 0; k < 5; k++) edge_pair(k, k);
        chk(fill == 0, "R9", "pipeline flushed", fill, 0);

        // random phase
        for (int t = 0; t < 4000; t++) begin
            bit c, st, rd, we;
            int wd;
            c  = ($urandom % 3 == 0) ? !mprev : mprev;
            st = ($urandom % 6 == 0);
            rd = ($urandom % 3 == 0);
            we = ($urandom % 150 == 0);
            wd = $urandom % 64;
            if (we) begin c = mprev; st = 0; end
            cyc(c, st, rd, we, 0 + wd, $urandom % 4096, $urandom % 4096);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule